// File: doc/BRIEF.md
# Flash Read Prefetch Line Buffer

This block speeds up reads from a slow, wide non-volatile memory array. It sits between a 32-bit system bus read port and an array that returns 128-bit lines. Recently used lines are held in two ways of four line buffers each. A read that finds its line in a buffer completes on the next clock with no wait states. A read that misses fetches the line from the array. The number of array wait states comes from a configuration input, so the timing can follow the operating frequency, voltage and temperature.

After an access the block can fetch the next sequential line ahead of demand. Whether it does depends on the access type (instruction or data), on the requesting master, and on whether a way may be filled by that type of traffic. Instruction fills go to way 0 and data fills go to way 1 when both are allowed. Each way replaces its least recently used line. An invalidate pulse, raised on any write or configuration change to the array space, discards every buffered line.

Top module: `flash_line_prefetcher`

## Requirements
- R1: After reset every line is invalid, `rd_done` and `arr_rd` are low, and `rd_ready` is high.
- R2: A request accepted (`rd_req` and `rd_ready` high at a clock edge) whose line is buffered raises `rd_done` with its data in the next cycle and starts no array read.
- R3: On a miss, `arr_rd` is high for exactly `cfg_wait`+1 cycles with `arr_line` equal to address bits [19:4] and held stable. `rd_done` rises in the cycle after the last one, so the miss latency is `cfg_wait`+2 cycles.
- R4: The returned 32-bit word is word n of the 128-bit line, bits [32n+31:32n], where n is address bits [3:2].
- R5: `cfg_pf_mode` selects which accesses trigger prefetch: 0 none, 1 instruction only, 2 data only, 3 any. A triggering hit starts a prefetch at once. A triggering miss prefetches after its own fill. The prefetch reads only line+1, and only if that line is not already buffered.
- R6: A prefetch is triggered only when bit `rd_master` of `cfg_pf_mst_en` is set.
- R7: An instruction fill goes to way 0 if `cfg_alloc_instr[0]` is set, otherwise to way 1 if `cfg_alloc_instr[1]` is set. A data fill goes to way 1 if `cfg_alloc_data[1]` is set, otherwise to way 0 if `cfg_alloc_data[0]` is set. With neither bit set the data is returned but not kept, and no prefetch is made.
- R8: A fill takes the lowest-numbered invalid line of its way, otherwise the least recently used one. Both hits and fills count as a use.
- R9: A miss accepted during a prefetch waits for the prefetch to end. If the prefetch was for the same line, the miss completes from it with no second array read and triggers no further prefetch. Otherwise the miss fill follows the prefetch. At most one request is outstanding at a time.
- R10: An `inval` pulse clears all lines, and a fill in flight at that moment is not installed.
- R11: A line is never held in both ways, and never twice in one way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_req | input | 1 | Read request |
| rd_addr | input | 20 | Byte address |
| rd_instr | input | 1 | 1 = instruction access, 0 = data access |
| rd_master | input | 2 | Requesting master ID |
| rd_ready | output | 1 | Request can be accepted this cycle |
| rd_done | output | 1 | Read data valid (one-cycle pulse) |
| rd_data | output | 32 | Read data word |
| arr_rd | output | 1 | Array read in progress |
| arr_line | output | 16 | Line address sent to the array |
| arr_data | input | 128 | Line data from the array, sampled on the last wait cycle |
| cfg_wait | input | 4 | Array read wait states |
| cfg_pf_mode | input | 2 | Prefetch trigger mode |
| cfg_pf_mst_en | input | 4 | Prefetch enable for each master |
| cfg_alloc_instr | input | 2 | Per-way allocation enable for instruction fills |
| cfg_alloc_data | input | 2 | Per-way allocation enable for data fills |
| inval | input | 1 | Invalidate all buffered lines |

## Verification
The assertions check, on every cycle, that:
- a hit is answered in the next cycle;
- the array address stays fixed while a read is in progress;
- no line is held twice;
- no request is accepted while another is outstanding;
- an invalidate leaves nothing to hit;
- each way's recency order stays a permutation.

Only the bench scenarios can show the rest:
- that the mode, master and allocation settings select the right lines to prefetch and keep;
- that the least recently used line is the one evicted;
- that a miss waiting on a matching prefetch costs no second array read.

The bench shows these by counting array cycles and by hit or miss latencies.

// File: rtl/flb_pkg.sv
package flb_pkg;
  typedef enum logic [1:0] {
    PF_OFF   = 2'd0,
    PF_INSTR = 2'd1,
    PF_DATA  = 2'd2,
    PF_ANY   = 2'd3
  } pf_mode_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_PF   = 2'd2
  } fsm_t;
endpackage

// File: rtl/flb_way.sv
module flb_way #(
  parameter int LINES  = 4,
  parameter int TAG_W  = 16,
  parameter int LINE_W = 128,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval,
  input  logic [TAG_W-1:0]  look_tag,
  input  logic [TAG_W-1:0]  probe_tag,
  input  logic              touch,
  input  logic              wr_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data,
  output logic              hit,
  output logic [LINE_W-1:0] hit_line,
  output logic              probe_hit
);
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [LINE_W-1:0] mem_q [LINES];
  logic [IDX_W-1:0]  age_q [LINES];
  logic [LINES-1:0]  vld_q;
  logic [LINES-1:0]  look_m, probe_m, oldest_v;
  logic [IDX_W-1:0]  hit_idx, vic_idx, use_idx;
  logic              use_en, vic_found;

  for (genvar i = 0; i < LINES; i++) begin : g_cmp
    assign look_m[i]   = vld_q[i] && (tag_q[i] == look_tag);
    assign probe_m[i]  = vld_q[i] && (tag_q[i] == probe_tag);
    assign oldest_v[i] = (age_q[i] == IDX_W'(LINES - 1));
  end

  assign hit       = |look_m;
  assign probe_hit = |probe_m;

  always_comb begin
    hit_idx = '0;
    for (int i = 0; i < LINES; i++)
      if (look_m[i]) hit_idx = IDX_W'(i);
  end

  // invalid line with the lowest index first, else the oldest line
  always_comb begin
    vic_idx   = '0;
    vic_found = 1'b0;
    for (int i = 0; i < LINES; i++)
      if (!vld_q[i] && !vic_found) begin
        vic_idx   = IDX_W'(i);
        vic_found = 1'b1;
      end
    if (!vic_found)
      for (int i = 0; i < LINES; i++)
        if (oldest_v[i]) vic_idx = IDX_W'(i);
  end

  assign hit_line = mem_q[hit_idx];
  assign use_en   = wr_en || (touch && hit);
  assign use_idx  = wr_en ? vic_idx : hit_idx;

  // storage without reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (wr_en && !inval) begin
      mem_q[vic_idx] <= wr_data;
      tag_q[vic_idx] <= wr_tag;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) vld_q <= '0;
    else if (inval) vld_q <= '0;
    else if (wr_en) vld_q[vic_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LINES; i++) age_q[i] <= IDX_W'(i);
    end else if (use_en) begin
      for (int i = 0; i < LINES; i++) begin
        if (IDX_W'(i) == use_idx) age_q[i] <= '0;
        else if (age_q[i] < age_q[use_idx]) age_q[i] <= age_q[i] + 1'b1;
      end
    end
  end

  // R8
  lru_order_chk: assert property (@(posedge clk) disable iff (rst) $onehot(oldest_v));
  // R11
  way_nodup_chk: assert property (@(posedge clk) disable iff (rst) $onehot0(look_m));
endmodule

// File: rtl/flb_policy.sv
module flb_policy #(
  parameter int NMST  = 4,
  localparam int MID_W = $clog2(NMST)
) (
  input  logic             instr,
  input  logic [MID_W-1:0] master,
  input  logic [1:0]       mode,
  input  logic [NMST-1:0]  mst_en,
  input  logic [1:0]       alloc_i,
  input  logic [1:0]       alloc_d,
  output logic             alloc_ok,
  output logic             alloc_way,
  output logic             pf_ok
);
  import flb_pkg::*;
  logic mode_ok;

  always_comb begin
    alloc_ok  = 1'b1;
    alloc_way = 1'b0;
    if (instr) begin
      if (alloc_i[0])      alloc_way = 1'b0;
      else if (alloc_i[1]) alloc_way = 1'b1;
      else                 alloc_ok  = 1'b0;
    end else begin
      if (alloc_d[1])      alloc_way = 1'b1;
      else if (alloc_d[0]) alloc_way = 1'b0;
      else                 alloc_ok  = 1'b0;
    end
  end

  always_comb begin
    case (pf_mode_t'(mode))
      PF_INSTR: mode_ok = instr;
      PF_DATA:  mode_ok = !instr;
      PF_ANY:   mode_ok = 1'b1;
      default:  mode_ok = 1'b0;
    endcase
  end

  assign pf_ok = mode_ok && mst_en[master] && alloc_ok;
endmodule

// File: rtl/flash_line_prefetcher.sv
module flash_line_prefetcher #(
  parameter int AW     = 20,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int LINES  = 4,
  parameter int NMST   = 4,
  parameter int WS_W   = 4,
  localparam int OFS_W  = $clog2(LINE_W / 8),
  localparam int TAG_W  = AW - OFS_W,
  localparam int MID_W  = $clog2(NMST),
  localparam int WPL    = LINE_W / WORD_W,
  localparam int WSEL_W = $clog2(WPL),
  localparam int NWAY   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_req,
  input  logic [AW-1:0]     rd_addr,
  input  logic              rd_instr,
  input  logic [MID_W-1:0]  rd_master,
  output logic              rd_ready,
  output logic              rd_done,
  output logic [WORD_W-1:0] rd_data,
  output logic              arr_rd,
  output logic [TAG_W-1:0]  arr_line,
  input  logic [LINE_W-1:0] arr_data,
  input  logic [WS_W-1:0]   cfg_wait,
  input  logic [1:0]        cfg_pf_mode,
  input  logic [NMST-1:0]   cfg_pf_mst_en,
  input  logic [1:0]        cfg_alloc_instr,
  input  logic [1:0]        cfg_alloc_data,
  input  logic              inval
);
  import flb_pkg::*;

  function automatic logic [WORD_W-1:0] word_of(input logic [LINE_W-1:0] ln,
                                                input logic [WSEL_W-1:0] ix);
    word_of = '0;
    for (int k = 0; k < WPL; k++)
      if (ix == WSEL_W'(k)) word_of = ln[k*WORD_W +: WORD_W];
  endfunction

  fsm_t st;
  logic [WS_W-1:0]   cnt;
  logic [TAG_W-1:0]  fill_line, pf_line, pend_line, probe_tag;
  logic              fill_way, fill_alloc, pf_arm, pf_way, stale;
  logic              pend, pend_way, pend_alloc, pend_pf;
  logic [WSEL_W-1:0] pend_word;

  logic [TAG_W-1:0]  req_line;
  logic [WSEL_W-1:0] req_word;
  logic [NWAY-1:0]   way_hit, way_probe, inst_we;
  logic [LINE_W-1:0] way_line [NWAY];
  logic [LINE_W-1:0] hit_line;
  logic              hit, probe_hit, last, acc, install;
  logic              pol_ok, pol_way, pol_pf;
  logic [OFS_W-WSEL_W-1:0] unused_lsb;

  assign req_line   = rd_addr[AW-1:OFS_W];
  assign req_word   = rd_addr[OFS_W-1:OFS_W-WSEL_W];
  assign unused_lsb = rd_addr[OFS_W-WSEL_W-1:0];

  assign last      = (st != ST_IDLE) && (cnt == cfg_wait);
  assign rd_ready  = (st == ST_IDLE) || ((st == ST_PF) && !pend && !last);
  assign acc       = rd_req && rd_ready;
  assign probe_tag = (st == ST_IDLE) ? TAG_W'(req_line + 1'b1) : pf_line;
  assign install   = last && fill_alloc && !stale && !inval;
  assign arr_rd    = (st != ST_IDLE);
  assign arr_line  = fill_line;

  for (genvar w = 0; w < NWAY; w++) begin : g_way
    assign inst_we[w] = install && (fill_way == w[0]);
    flb_way #(.LINES(LINES), .TAG_W(TAG_W), .LINE_W(LINE_W)) i_way (
      .clk(clk), .rst(rst), .inval(inval),
      .look_tag(req_line), .probe_tag(probe_tag),
      .touch(acc && way_hit[w]),
      .wr_en(inst_we[w]), .wr_tag(fill_line), .wr_data(arr_data),
      .hit(way_hit[w]), .hit_line(way_line[w]), .probe_hit(way_probe[w])
    );
  end

  assign hit       = |way_hit;
  assign probe_hit = |way_probe;
  assign hit_line  = way_hit[1] ? way_line[1] : way_line[0];

  flb_policy #(.NMST(NMST)) i_policy (
    .instr(rd_instr), .master(rd_master), .mode(cfg_pf_mode),
    .mst_en(cfg_pf_mst_en), .alloc_i(cfg_alloc_instr), .alloc_d(cfg_alloc_data),
    .alloc_ok(pol_ok), .alloc_way(pol_way), .pf_ok(pol_pf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;      cnt <= '0;         rd_done <= 1'b0;  rd_data <= '0;
      fill_line <= '0;    fill_way <= 1'b0;  fill_alloc <= 1'b0;
      pf_arm <= 1'b0;     pf_line <= '0;     pf_way <= 1'b0;   stale <= 1'b0;
      pend <= 1'b0;       pend_line <= '0;   pend_word <= '0;
      pend_way <= 1'b0;   pend_alloc <= 1'b0; pend_pf <= 1'b0;
    end else begin
      rd_done <= 1'b0;
      if (inval && st != ST_IDLE) stale <= 1'b1;
      if (st != ST_IDLE && !last) cnt <= cnt + 1'b1;
      case (st)
        ST_IDLE: if (acc) begin
          if (hit) begin
            rd_done <= 1'b1;
            rd_data <= word_of(hit_line, req_word);
            if (pol_pf && !probe_hit) begin
              st <= ST_PF; fill_line <= TAG_W'(req_line + 1'b1);
              fill_way <= pol_way; fill_alloc <= 1'b1; cnt <= '0; stale <= 1'b0;
            end
          end else begin
            st <= ST_FILL; fill_line <= req_line; fill_way <= pol_way;
            fill_alloc <= pol_ok; cnt <= '0; stale <= 1'b0; pend_word <= req_word;
            pf_arm <= pol_pf; pf_line <= TAG_W'(req_line + 1'b1); pf_way <= pol_way;
          end
        end
        ST_FILL: if (last) begin
          rd_done <= 1'b1;
          rd_data <= word_of(arr_data, pend_word);
          pf_arm  <= 1'b0;
          if (pf_arm && !probe_hit) begin
            st <= ST_PF; fill_line <= pf_line; fill_way <= pf_way;
            fill_alloc <= 1'b1; cnt <= '0; stale <= 1'b0;
          end else st <= ST_IDLE;
        end
        ST_PF: begin
          if (acc) begin
            if (hit) begin
              rd_done <= 1'b1;
              rd_data <= word_of(hit_line, req_word);
            end else begin
              pend <= 1'b1; pend_line <= req_line; pend_word <= req_word;
              pend_way <= pol_way; pend_alloc <= pol_ok; pend_pf <= pol_pf;
            end
          end
          if (last) begin
            if (pend && pend_line == fill_line && !stale && !inval) begin
              rd_done <= 1'b1;
              rd_data <= word_of(arr_data, pend_word);
              pend <= 1'b0; st <= ST_IDLE;
            end else if (pend) begin
              st <= ST_FILL; fill_line <= pend_line; fill_way <= pend_way;
              fill_alloc <= pend_alloc; cnt <= '0; stale <= 1'b0; pend <= 1'b0;
              pf_arm <= pend_pf; pf_line <= TAG_W'(pend_line + 1'b1); pf_way <= pend_way;
            end else st <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  logic [1:0] outst_q;
  always_ff @(posedge clk) begin
    if (rst) outst_q <= '0;
    else outst_q <= outst_q + {1'b0, acc} - {1'b0, rd_done};
  end

  // R2
  hit_done_chk: assert property (@(posedge clk) disable iff (rst) (acc && hit) |=> rd_done);
  // R3
  fill_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (arr_rd && !last) |=> (arr_rd && $stable(arr_line)));
  // R10
  inval_clear_chk: assert property (@(posedge clk) disable iff (rst) inval |=> (way_hit == '0));
  // R11
  nodup_chk: assert property (@(posedge clk) disable iff (rst) !(way_hit[0] && way_hit[1]));
  // R9
  one_outstanding_chk: assert property (@(posedge clk) disable iff (rst) outst_q <= 2'd1);
endmodule

// File: tb/test_flash_line_prefetcher.sv
module test_flash_line_prefetcher;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd_req = 1'b0, rd_instr = 1'b0, inval = 1'b0;
  logic [19:0] rd_addr = '0;
  logic [1:0]  rd_master = '0;
  logic rd_ready, rd_done, arr_rd;
  logic [31:0] rd_data;
  logic [15:0] arr_line;
  logic [127:0] arr_data;
  logic [3:0] cfg_wait = 4'd2;
  logic [1:0] cfg_pf_mode = 2'd1;
  logic [3:0] cfg_pf_mst_en = 4'b0001;
  logic [1:0] cfg_alloc_instr = 2'b01, cfg_alloc_data = 2'b10;

  int total = 0, bad = 0, arr_cnt = 0, lat = 0;
  logic [31:0] got;

  always #5 clk = ~clk;

  function automatic logic [31:0] exp_word(input logic [19:0] a);
    exp_word = {a[19:4], 8'h5A, 6'd0, a[3:2]};
  endfunction

  function automatic logic [127:0] mk_line(input logic [15:0] ln);
    for (int k = 0; k < 4; k++) mk_line[k*32 +: 32] = {ln, 8'h5A, 6'd0, 2'(k)};
  endfunction

  assign arr_data = arr_rd ? mk_line(arr_line) : '0;
  always @(posedge clk) if (arr_rd) arr_cnt <= arr_cnt + 1;

  flash_line_prefetcher i_flash_line_prefetcher (
    .clk(clk), .rst(rst), .rd_req(rd_req), .rd_addr(rd_addr), .rd_instr(rd_instr),
    .rd_master(rd_master), .rd_ready(rd_ready), .rd_done(rd_done), .rd_data(rd_data),
    .arr_rd(arr_rd), .arr_line(arr_line), .arr_data(arr_data), .cfg_wait(cfg_wait),
    .cfg_pf_mode(cfg_pf_mode), .cfg_pf_mst_en(cfg_pf_mst_en),
    .cfg_alloc_instr(cfg_alloc_instr), .cfg_alloc_data(cfg_alloc_data), .inval(inval)
  );

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic do_read(input logic [19:0] a, input logic ins, input logic [1:0] m);
    int guard = 0;
    while (!rd_ready && guard < 1000) begin @(negedge clk); guard++; end
    rd_req = 1'b1; rd_addr = a; rd_instr = ins; rd_master = m;
    @(negedge clk);
    rd_req = 1'b0;
    lat = 1;
    while (!rd_done && lat < 1000) begin @(negedge clk); lat++; end
    got = rd_data;
  endtask

  task automatic wait_idle();
    int guard = 0;
    while ((arr_rd || !rd_ready) && guard < 1000) begin @(negedge clk); guard++; end
  endtask

  task automatic rd_expect(input logic [19:0] a, input logic ins, input logic [1:0] m,
                           input bit exp_hit, input string tag);
    int want;
    wait_idle();
    do_read(a, ins, m);
    want = exp_hit ? 1 : int'(cfg_wait) + 2;
    chk(lat == want, {tag, " latency"}, lat, want);
    chk(got == exp_word(a), {tag, " data"}, got, exp_word(a));
  endtask

  // addr, instr, master, expected hit
  localparam logic [23:0] TBL [12] = '{
    {20'h00100, 1'b1, 2'd0, 1'b0}, {20'h00104, 1'b1, 2'd0, 1'b1},
    {20'h00110, 1'b1, 2'd0, 1'b1}, {20'h0012C, 1'b1, 2'd0, 1'b1},
    {20'h00400, 1'b0, 2'd0, 1'b0}, {20'h00410, 1'b0, 2'd0, 1'b0},
    {20'h00408, 1'b0, 2'd0, 1'b1}, {20'h00800, 1'b1, 2'd1, 1'b0},
    {20'h00810, 1'b1, 2'd1, 1'b0}, {20'h00120, 1'b1, 2'd1, 1'b1},
    {20'h00100, 1'b1, 2'd1, 1'b0}, {20'h00130, 1'b1, 2'd1, 1'b0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(rd_done == 1'b0, "R1 rd_done", rd_done, 0);
    chk(arr_rd == 1'b0, "R1 arr_rd", arr_rd, 0);
    chk(rd_ready == 1'b1, "R1 rd_ready", rd_ready, 1);

    // R2 R3 R4 R5 R6 R8: prefetch, hits and replacement
    for (int i = 0; i < 12; i++)
      rd_expect(TBL[i][23:4], TBL[i][3], TBL[i][2:1], TBL[i][0], $sformatf("R8 vec%0d", i));

    // R2 no array read on hit
    wait_idle(); base = arr_cnt;
    rd_expect(20'h00120, 1'b1, 2'd1, 1'b1, "R2 hit");
    chk(arr_cnt == base, "R2 no array read", arr_cnt - base, 0);

    // R7 bypass when no data way allowed
    cfg_alloc_data = 2'b00;
    rd_expect(20'h00A00, 1'b0, 2'd0, 1'b0, "R7 bypass first");
    rd_expect(20'h00A04, 1'b0, 2'd0, 1'b0, "R7 bypass second");
    // R7 data falls back to way 0
    cfg_alloc_data = 2'b01;
    rd_expect(20'h00B00, 1'b0, 2'd0, 1'b0, "R7 way0 fill");
    rd_expect(20'h00B08, 1'b0, 2'd0, 1'b1, "R7 way0 hit");
    cfg_alloc_data = 2'b10;

    // R5 data-only mode
    cfg_pf_mode = 2'd2;
    rd_expect(20'h00C00, 1'b0, 2'd0, 1'b0, "R5 data miss");
    rd_expect(20'h00C10, 1'b0, 2'd0, 1'b1, "R5 data prefetched");
    rd_expect(20'h00E00, 1'b1, 2'd0, 1'b0, "R5 instr miss");
    rd_expect(20'h00E10, 1'b1, 2'd0, 1'b0, "R5 instr not prefetched");

    // R6 per-master enable
    cfg_pf_mode = 2'd3; cfg_pf_mst_en = 4'b0010;
    rd_expect(20'h01000, 1'b0, 2'd1, 1'b0, "R6 m1 miss");
    rd_expect(20'h01010, 1'b0, 2'd1, 1'b1, "R6 m1 prefetched");
    rd_expect(20'h01200, 1'b0, 2'd0, 1'b0, "R6 m0 miss");
    rd_expect(20'h01210, 1'b0, 2'd0, 1'b0, "R6 m0 not prefetched");

    // R9 miss on the line being prefetched
    cfg_pf_mst_en = 4'b1111; cfg_wait = 4'd6;
    wait_idle(); base = arr_cnt;
    do_read(20'h02000, 1'b0, 2'd1);
    do_read(20'h02014, 1'b0, 2'd1);
    chk(got == exp_word(20'h02014), "R9 data from prefetch", got, exp_word(20'h02014));
    wait_idle();
    chk(arr_cnt - base == 14, "R9 single array read", arr_cnt - base, 14);
    // R9 miss on another line during prefetch
    base = arr_cnt;
    do_read(20'h03000, 1'b0, 2'd1);
    do_read(20'h03400, 1'b0, 2'd1);
    chk(got == exp_word(20'h03400), "R9 queued miss data", got, exp_word(20'h03400));
    wait_idle();
    chk(arr_cnt - base == 28, "R9 queued array reads", arr_cnt - base, 28);
    rd_expect(20'h03010, 1'b0, 2'd1, 1'b1, "R9 earlier prefetch kept");

    // R10 invalidate
    cfg_pf_mode = 2'd0; cfg_wait = 4'd2;
    rd_expect(20'h05000, 1'b0, 2'd0, 1'b0, "R10 fill");
    rd_expect(20'h05004, 1'b0, 2'd0, 1'b1, "R10 hit before");
    inval = 1'b1; @(negedge clk); inval = 1'b0;
    rd_expect(20'h05008, 1'b0, 2'd0, 1'b0, "R10 miss after");
    cfg_wait = 4'd6;
    wait_idle();
    fork
      do_read(20'h05100, 1'b0, 2'd0);
      begin repeat (3) @(negedge clk); inval = 1'b1; @(negedge clk); inval = 1'b0; end
    join
    chk(got == exp_word(20'h05100), "R10 in-flight data", got, exp_word(20'h05100));
    rd_expect(20'h05100, 1'b0, 2'd0, 1'b0, "R10 in-flight not kept");

    // R3 zero wait states
    cfg_wait = 4'd0;
    wait_idle(); base = arr_cnt;
    rd_expect(20'h06000, 1'b0, 2'd0, 1'b0, "R3 ws0 miss");
    chk(arr_cnt - base == 1, "R3 ws0 array cycles", arr_cnt - base, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule